// File: doc/BRIEF.md
# I2C SCL Phase Timing Generator

This block turns a fast peripheral clock into the SCL waveform of an I2C controller. A power-of-two prescaler produces a slow tick. Two phase counters then count ticks for the low half of SCL and for the high half. The prescaler exponent and both phase lengths come from one timing word. Each phase length is stored as the number of ticks minus one.

The block drives an SCL request (1 = release the line, 0 = pull it low) and reads back the sampled line. The high phase does not count until the sampled line is actually high. A target that holds SCL low therefore stretches the period and does not shorten it. The block also gives one-cycle strobes to a bit engine: a strobe when SCL is pulled low, a strobe in the middle of the low phase for changing SDA, and a strobe in the middle of the high phase for sampling SDA.

When disabled, the block releases SCL and stays quiet. Any change of the timing fields restarts the waveform at the start of a low phase with cleared counters.

Top module: `scl_clock_gen`

## Requirements
- R1: Timing word fields: SCL high count at bits [19:16], SCL low count at bits [15:12], prescaler exponent e at bits [3:0]. All other bits have no effect on the waveform.
- R2: With SCL unstretched, `scl_o` stays 0 for exactly (low+1)·2^e clock cycles after each falling edge.
- R3: The full SCL period, measured from falling edge to falling edge with no stretching, is 2^e·((high+1)+(low+1)) clock cycles.
- R4: A count field of 0 gives a phase of one prescaled tick. The exponent reaches 15, which gives a tick every 32768 cycles.
- R5: While `scl_o` is 1 and `scl_in` is sampled 0 in the high phase, the high phase and the prescaler are frozen. Each such cycle adds exactly one cycle to the high phase and produces no tick.
- R6: A change of any timing field while enabled restarts the low phase with cleared counters, without an extra falling strobe if SCL is already low. SCL then rises (low'+1)·2^e' cycles after the first edge that samples the new word.
- R7: While `enable` is sampled 0, all outputs settle to the released state one cycle later: `scl_o`=1, and `tick_o`, `fall_o`, `low_mid_o` and `high_mid_o` are 0. This is also the reset state.
- R8: `low_mid_o` pulses for one cycle ((low>>1)+1)·2^e cycles after the falling edge of SCL.
- R9: `high_mid_o` pulses for one cycle S+((high>>1)+1)·2^e cycles after the rise of `scl_o`, where S is the number of stretched cycles.
- R10: `tick_o` pulses once per prescaled tick. Exactly (low+1)+(high+1) pulses fall in each period, counted from after one falling edge up to and including the next.
- R11: `fall_o` is 1 in exactly those cycles in which `scl_o` has just gone from 1 to 0.
- R12: From the idle state, SCL is pulled low and `fall_o` pulses in the first cycle after `enable` is sampled 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the SCL generator |
| timing_word | input | 32 | Exponent, low count and high count fields |
| scl_in | input | 1 | Sampled SCL line level |
| tick_o | output | 1 | Prescaled tick strobe |
| scl_o | output | 1 | SCL request: 1 release, 0 drive low |
| fall_o | output | 1 | Strobe on the cycle SCL is pulled low |
| low_mid_o | output | 1 | Middle-of-low strobe for SDA update |
| high_mid_o | output | 1 | Middle-of-high strobe for SDA sample |

## Verification
The assertions check the following on every cycle:
- the released, silent state one cycle after `enable` is sampled 0;
- the exact match between `fall_o` and falling `scl_o`;
- the freeze of SCL and ticks while the line is held low in the high phase;
- that the two mid strobes never coincide, fall in the right phase and land on ticks.

Cycle counts need whole scenarios, so only the bench's runs show them:
- phase lengths, period length and strobe offsets for many exponent and count mixes, with and without stretching;
- the restart length after a word change;
- the 32768-cycle tick at the largest exponent.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/scl_timing_decode.sv
// Splits the timing word into its fields and flags any field change.
module scl_timing_decode #(
  parameter int WORD_W  = 32,
  parameter int PH_W    = 4,
  parameter int EXP_W   = 4,
  parameter int HI_LSB  = 16,
  parameter int LO_LSB  = 12,
  parameter int EXP_LSB = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word,
  output logic [PH_W-1:0]   hi_len,
  output logic [PH_W-1:0]   lo_len,
  output logic [EXP_W-1:0]  exp_sel,
  output logic              chg
);
  localparam int FLD_W = 2 * PH_W + EXP_W;

  logic [FLD_W-1:0] fld;
  logic [FLD_W-1:0] fld_q;

  assign hi_len  = word[HI_LSB +: PH_W];
  assign lo_len  = word[LO_LSB +: PH_W];
  assign exp_sel = word[EXP_LSB +: EXP_W];
  assign fld     = {hi_len, lo_len, exp_sel};

  always_ff @(posedge clk) begin
    if (rst) fld_q <= '0;
    else     fld_q <= fld;
  end

  assign chg = (fld != fld_q);
endmodule

// File: rtl/scl_prescaler.sv
// Power-of-two tick generator with stall and clear.
module scl_prescaler #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EXP_W-1:0] exp_sel,
  input  logic             run,
  input  logic             stall,
  input  logic             clear,
  output logic             tick
);
  localparam int PRE_W = (1 << EXP_W) - 1;

  logic [PRE_W-1:0] pre;
  logic [PRE_W:0]   lim_w;

  assign lim_w = ({{PRE_W{1'b0}}, 1'b1} << exp_sel) - 1'b1;
  assign tick  = run && !stall && !clear && (pre == lim_w[PRE_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst || clear || !run || tick) pre <= '0;
    else if (!stall)                  pre <= pre + 1'b1;
  end
endmodule

// File: rtl/scl_phase_fsm.sv
// Low/high phase sequencer with stretch wait and mid-phase strobes.
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            restart,
  input  logic            tick,
  input  logic [PH_W-1:0] hi_len,
  input  logic [PH_W-1:0] lo_len,
  output phase_e          st,
  output logic            scl_q,
  output logic            fall_q,
  output logic            lmid_q,
  output logic            hmid_q
);
  phase_e          nxt;
  logic [PH_W-1:0] cnt, cnt_n;
  logic            lmid_n, hmid_n;

  always_comb begin
    nxt   = st;
    cnt_n = cnt;
    if (!en) begin
      nxt   = PH_IDLE;
      cnt_n = '0;
    end else if (st == PH_IDLE || restart) begin
      nxt   = PH_LOW;
      cnt_n = '0;
    end else if (tick) begin
      if (st == PH_LOW) begin
        if (cnt == lo_len) begin
          nxt   = PH_HIGH;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end else begin
        if (cnt == hi_len) begin
          nxt   = PH_LOW;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
    end
  end

  assign lmid_n = tick && (st == PH_LOW)  && (cnt == (lo_len >> 1));
  assign hmid_n = tick && (st == PH_HIGH) && (cnt == (hi_len >> 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= PH_IDLE;
      cnt    <= '0;
      scl_q  <= 1'b1;
      fall_q <= 1'b0;
      lmid_q <= 1'b0;
      hmid_q <= 1'b0;
    end else begin
      st     <= nxt;
      cnt    <= cnt_n;
      scl_q  <= (nxt != PH_LOW);
      fall_q <= (nxt == PH_LOW) && (st != PH_LOW);
      lmid_q <= lmid_n;
      hmid_q <= hmid_n;
    end
  end
endmodule

// File: rtl/scl_clock_gen.sv
// SCL phase timing generator: prescaler, phase counters, stretch wait.
module scl_clock_gen
  import scl_gen_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PH_W   = 4,
  parameter int EXP_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [WORD_W-1:0] timing_word,
  input  logic              scl_in,
  output logic              tick_o,
  output logic              scl_o,
  output logic              fall_o,
  output logic              low_mid_o,
  output logic              high_mid_o
);
  logic [PH_W-1:0]  hi_len, lo_len;
  logic [EXP_W-1:0] exp_sel;
  logic             chg;
  logic             run, stall, tick, tick_q;
  phase_e           st;

  scl_timing_decode #(
    .WORD_W(WORD_W), .PH_W(PH_W), .EXP_W(EXP_W),
    .HI_LSB(16), .LO_LSB(12), .EXP_LSB(0)
  ) u_dec (
    .clk(clk), .rst(rst), .word(timing_word),
    .hi_len(hi_len), .lo_len(lo_len), .exp_sel(exp_sel), .chg(chg)
  );

  assign run   = enable && (st != PH_IDLE);
  assign stall = (st == PH_HIGH) && !scl_in;

  scl_prescaler #(.EXP_W(EXP_W)) u_pre (
    .clk(clk), .rst(rst), .exp_sel(exp_sel),
    .run(run), .stall(stall), .clear(chg), .tick(tick)
  );

  scl_phase_fsm #(.PH_W(PH_W)) u_fsm (
    .clk(clk), .rst(rst), .en(enable), .restart(chg), .tick(tick),
    .hi_len(hi_len), .lo_len(lo_len), .st(st),
    .scl_q(scl_o), .fall_q(fall_o), .lmid_q(low_mid_o), .hmid_q(high_mid_o)
  );

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= tick;
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/scl_clock_gen_chk.sv
module scl_clock_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        enable,
  input logic [31:0] timing_word,
  input logic        scl_in,
  input logic        tick_o,
  input logic        scl_o,
  input logic        fall_o,
  input logic        low_mid_o,
  input logic        high_mid_o
);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (scl_o && !tick_o && !fall_o && !low_mid_o && !high_mid_o));

  // R11
  fall_marks_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_o) |-> fall_o);

  // R11
  fall_only_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    fall_o |-> $fell(scl_o));

  // R5
  stretch_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && $past(enable) && scl_o && !scl_in && $stable(timing_word)) |=> scl_o);

  // R5
  stretch_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_o && !scl_in) |=> !tick_o);

  // R8
  mid_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({low_mid_o, high_mid_o}));

  // R8
  low_mid_phase_chk: assert property (@(posedge clk) disable iff (rst)
    low_mid_o |-> (!$past(scl_o) && tick_o));

  // R9
  high_mid_phase_chk: assert property (@(posedge clk) disable iff (rst)
    high_mid_o |-> ($past(scl_o) && tick_o));
endmodule

bind scl_clock_gen scl_clock_gen_chk u_chk (
  .clk(clk), .rst(rst), .enable(enable), .timing_word(timing_word),
  .scl_in(scl_in), .tick_o(tick_o), .scl_o(scl_o), .fall_o(fall_o),
  .low_mid_o(low_mid_o), .high_mid_o(high_mid_o)
);

// File: tb/scl_clock_gen_tb.sv
`timescale 1ns/1ps
module scl_clock_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [31:0] timing_word = '0;
  logic        scl_in;
  logic        tick_o, scl_o, fall_o, low_mid_o, high_mid_o;

  logic hold = 1'b0;
  int   cyc = 0, t_fall = 0, t_rise = 0, t_lmid = 0, t_hmid = 0;
  int   n_fall = 0, tick_cnt = 0, tick_snap = 0, cnt_s = 0, stretch_s = 0;
  logic prev_scl = 1'b1;
  int   tests = 0, fails = 0;

  always #5 clk = ~clk;
  assign scl_in = scl_o & ~hold;

  scl_clock_gen u_dut (
    .clk(clk), .rst(rst), .enable(enable), .timing_word(timing_word),
    .scl_in(scl_in), .tick_o(tick_o), .scl_o(scl_o), .fall_o(fall_o),
    .low_mid_o(low_mid_o), .high_mid_o(high_mid_o)
  );

  // event monitor and line-stretch model
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      prev_scl = 1'b1;
      hold     = 1'b0;
    end else begin
      if (scl_o && !prev_scl) t_rise = cyc;
      if (low_mid_o)  t_lmid = cyc;
      if (high_mid_o) t_hmid = cyc;
      if (!scl_o && prev_scl) begin
        t_fall    = cyc;
        tick_snap = tick_cnt + int'(tick_o);
        tick_cnt  = 0;
        hold      = (stretch_s > 0);
        cnt_s     = 0;
        n_fall    = n_fall + 1;
      end else begin
        tick_cnt = tick_cnt + int'(tick_o);
      end
      if (scl_o && hold) begin
        cnt_s = cnt_s + 1;
        if (cnt_s == stretch_s + 1) hold = 1'b0;
      end
      prev_scl = scl_o;
    end
  end

  function automatic logic [31:0] mk_word(input int e, input int h, input int l,
                                          input logic junk);
    logic [31:0] w;
    w = '0;
    w[19:16] = h[3:0];
    w[15:12] = l[3:0];
    w[3:0]   = e[3:0];
    if (junk) begin
      w[31:20] = 12'hA5C;
      w[11:4]  = 8'h9B;
    end
    return w;
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    tests = tests + 1;
    if (act != expv) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wait_falls(input int n);
    int target;
    target = n_fall + n;
    while (n_fall < target) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic measure(input int e, input int h, input int l, input int s,
                         input logic junk);
    int f0, f1;
    string rp;
    @(negedge clk);
    stretch_s   = s;
    timing_word = mk_word(e, h, l, junk);
    enable      = 1'b1;
    wait_falls(1);
    f0 = t_fall;
    wait_falls(1);
    f1 = t_fall;
    rp = (s > 0) ? "R5 period" : (junk ? "R1 period" : "R3 period");
    chk(junk ? "R1 low" : "R2 low", t_rise - f0, (l + 1) << e);
    chk("R8 low_mid", t_lmid - f0, ((l >> 1) + 1) << e);
    chk("R9 high_mid", t_hmid - t_rise, s + (((h >> 1) + 1) << e));
    chk(rp, f1 - f0, (((l + 1) + (h + 1)) << e) + s);
    chk("R10 ticks", tick_snap, l + h + 2);
  endtask

  task automatic restart_check(input int e, input int h, input int l, input string req);
    int k, nf;
    @(negedge clk);
    timing_word = mk_word(e, h, l, 1'b0);
    nf = n_fall;
    k  = 0;
    do begin
      @(negedge clk); #1;
      k = k + 1;
    end while (!scl_o);
    chk(req, k, ((l + 1) << e) + 1);
    chk("R6 no extra fall", n_fall - nf, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests = tests + 1;
    fails = fails + 1;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int rnd, bad;
    rnd = $urandom(32'd4242);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R7 reset state
    chk("R7 reset scl", int'(scl_o), 1);
    chk("R7 reset strobes", int'({tick_o, fall_o, low_mid_o, high_mid_o}), 0);

    // R12 enable from idle
    timing_word = mk_word(1, 2, 3, 1'b0);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk); #1;
    chk("R12 scl low", int'(scl_o), 0);
    chk("R12 fall strobe", int'(fall_o), 1);

    measure(1, 2, 3, 0, 1'b0);
    measure(0, 0, 0, 0, 1'b0);   // R4 one-tick phases
    measure(0, 15, 15, 0, 1'b0);
    measure(2, 5, 4, 3, 1'b0);   // R5 stretch
    measure(0, 1, 0, 7, 1'b0);   // R5 stretch on shortest phase
    measure(1, 6, 9, 0, 1'b1);   // R1 junk bits

    for (int i = 0; i < 14; i++) begin
      int e, h, l, s;
      e = int'($urandom % 4);
      h = int'($urandom % 16);
      l = int'($urandom % 16);
      s = int'($urandom % 6);
      measure(e, h, l, s, 1'b0);
    end

    // R6 restart during low phase
    stretch_s = 0;
    measure(0, 15, 15, 0, 1'b0);
    wait_falls(1);
    repeat (3) @(negedge clk);
    restart_check(2, 1, 5, "R6 restart");

    // R7 idle: outputs quiet, word changes ignored
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      if (i == 5) timing_word = mk_word(3, 7, 2, 1'b0);
      @(negedge clk); #1;
      if (!scl_o || tick_o || fall_o || low_mid_o || high_mid_o) bad = bad + 1;
    end
    chk("R7 idle quiet cycles", bad, 0);

    // R4 largest exponent
    timing_word = mk_word(0, 15, 15, 1'b0);
    @(negedge clk);
    enable = 1'b1;
    repeat (4) @(negedge clk);
    restart_check(15, 0, 0, "R4 max exponent");
    @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule